// File: doc/BRIEF.md
# Timer Interrupt Line Router with Legacy Takeover

This block turns the expiry strobes of a set of timer channels into levels on a bank of interrupt request wires. Each channel carries a route number that selects the wire it drives. It also carries a trigger kind. A level-kind channel latches its request and holds the wire high until it is cleared. An edge-kind channel produces a single one-clock pulse for each strobe. When several sources aim at one wire, the wire is their OR.

Two older interrupt sources also enter the block: a periodic interval timer (PIT) and a real-time clock (RTC). In normal operation they pass through to wire 0 and wire 8. A global takeover mode changes this. In takeover mode, channel 0 is pinned to wire 0 and channel 1 to wire 8, whatever their route fields hold. The PIT and RTC inputs are cut off from those wires, and a PIT-enable output is dropped so the PIT itself can be shut off.

The RTC level is recorded on every clock, including in takeover mode. On leaving takeover mode, wire 8 resumes at the recorded level at once. Wire 0 stays low until the PIT input next changes. Every pin is a plain level or strobe. All inputs are registered, so every effect appears one clock after the input is applied.

Top module: `irq_line_router`

## Requirements
- R1: While reset is held and in the first cycle after it, every `irq_o` bit is 0 and `pit_enable_o` is 1, and the recorded RTC level is 0.
- R2: A fire strobe on a channel whose trigger input is 1 (level kind) sets `irq_o[route]` high one clock later. The wire stays high until that channel's clear strobe.
- R3: A fire strobe on a channel whose trigger input is 0 (edge kind) drives `irq_o[route]` high for exactly one clock, one clock later. Strobes on consecutive cycles give consecutive high cycles.
- R4: A clear strobe lowers a held level request one clock later, and it wins over a fire strobe in the same cycle.
- R5: In takeover mode (`legacy_mode_i`=1), channel 0 drives wire 0 and channel 1 drives wire 8, and the route fields of channels 0 and 1 have no effect.
- R6: Channels 2 and up, and channels 0 and 1 outside takeover mode, drive the wire whose index equals their route field. A route value of NUM_LINES or more drives no wire.
- R7: Each wire is the OR of every source aimed at it.
- R8: Outside takeover mode, a change on `pit_irq_i` appears on wire 0 one clock later, and `rtc_irq_i` appears on wire 8 one clock later.
- R9: The RTC level is recorded on every clock. On the first cycle after leaving takeover mode, wire 8 shows the recorded level, including a change made during takeover mode.
- R10: Entering takeover mode drops `pit_enable_o` and removes the PIT and RTC contributions from wires 0 and 8. PIT changes made during takeover mode are lost.
- R11: Leaving takeover mode raises `pit_enable_o` and leaves the PIT contribution on wire 0 low until `pit_irq_i` next changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_fire_i | input | NUM_CH | Per-channel expiry strobe |
| ch_clear_i | input | NUM_CH | Per-channel clear strobe (status acknowledge or channel disable) |
| ch_trig_i | input | NUM_CH | Per-channel trigger kind: 1 = level, 0 = edge |
| ch_route_i | input | NUM_CH x ROUTE_W | Per-channel wire index |
| legacy_mode_i | input | 1 | Takeover mode select |
| pit_irq_i | input | 1 | Periodic interval timer interrupt level |
| rtc_irq_i | input | 1 | Real-time clock interrupt level |
| irq_o | output | NUM_LINES | Interrupt request wires |
| pit_enable_o | output | 1 | High when the PIT may run (takeover mode off) |

## Verification
The hardest situations to reach are the two exits from takeover mode. In one, the PIT input is already high when the mode ends: wire 0 must stay low even though the input is high. In the other, the RTC changed while its wire was cut off. The stimulus raises the PIT and RTC before entering takeover mode, moves both while the mode is on, and then leaves the mode. It also pulses the mode on and off on back-to-back cycles. A behavioural model follows the recorded RTC level and the last PIT level seen, and it is compared with every wire on every clock.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/irq_chan_latch.sv
module irq_chan_latch
  import irq_router_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic clear_i,
  input  logic trig_i,
  output logic active_o
);
  logic held_q;
  logic pulse_q;
  trig_e kind;

  assign kind = trig_e'(trig_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (clear_i)                            held_q <= 1'b0;
      else if (fire_i && kind == TRIG_LEVEL)  held_q <= 1'b1;
      pulse_q <= fire_i && (kind == TRIG_EDGE) && !clear_i;
    end
  end

  assign active_o = held_q | pulse_q;

  // R2: a level fire raises the request next cycle
  p_level_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && kind == TRIG_LEVEL && !clear_i) |=> active_o);
  // R2: a held request persists without a clear
  p_level_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !clear_i) |=> held_q);
  // R3: a pulse never outlives its strobe
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && !fire_i) |=> !pulse_q);
  // R4: clear wins over a simultaneous fire
  p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !held_q);
endmodule

// File: rtl/irq_route_sel.sv
module irq_route_sel #(
  parameter int unsigned NUM_LINES = 24,
  parameter int unsigned ROUTE_W   = 5,
  parameter int unsigned CH_IDX    = 0,
  parameter int unsigned LEG0_LINE = 0,
  parameter int unsigned LEG1_LINE = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ROUTE_W-1:0]   route_i,
  input  logic                 takeover_i,
  input  logic                 active_i,
  output logic [NUM_LINES-1:0] hit_o
);
  logic [ROUTE_W-1:0] route_q;
  logic [ROUTE_W-1:0] eff_route;

  always_ff @(posedge clk) begin
    if (!rst_n) route_q <= '0;
    else        route_q <= route_i;
  end

  generate
    if (CH_IDX == 0) begin : g_pin0
      assign eff_route = takeover_i ? ROUTE_W'(LEG0_LINE) : route_q;
    end else if (CH_IDX == 1) begin : g_pin1
      assign eff_route = takeover_i ? ROUTE_W'(LEG1_LINE) : route_q;
    end else begin : g_free
      assign eff_route = route_q;
    end
  endgenerate

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_dec
    assign hit_o[l] = active_i && (eff_route == ROUTE_W'(l));
  end

  // R6: a channel reaches at most one wire
  p_one_wire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_o));
  // R6: an inactive channel reaches no wire
  p_idle_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |-> (hit_o == '0));

  if (CH_IDX == 0) begin : g_a0
    // R5: pinned wire in takeover mode
    p_pin0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (takeover_i && active_i) |-> hit_o[LEG0_LINE]);
  end else if (CH_IDX == 1) begin : g_a1
    // R5: pinned wire in takeover mode
    p_pin1_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (takeover_i && active_i) |-> hit_o[LEG1_LINE]);
  end
endmodule

// File: rtl/irq_legacy_ctl.sv
module irq_legacy_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic pit_i,
  input  logic rtc_i,
  output logic takeover_o,
  output logic pit_en_o,
  output logic pit_line_o,
  output logic rtc_line_o
);
  logic mode_q;
  logic pit_seen_q;
  logic pit_line_q;
  logic rtc_keep_q;
  logic mode_flip;

  assign mode_flip = mode_q != mode_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= 1'b0;
      pit_seen_q <= 1'b0;
      pit_line_q <= 1'b0;
      rtc_keep_q <= 1'b0;
    end else begin
      mode_q     <= mode_i;
      pit_seen_q <= pit_i;
      rtc_keep_q <= rtc_i;
      if (mode_flip)                            pit_line_q <= 1'b0;
      else if (!mode_i && pit_i != pit_seen_q)  pit_line_q <= pit_i;
    end
  end

  assign takeover_o = mode_q;
  assign pit_en_o   = !mode_q;
  assign pit_line_o = pit_line_q;
  assign rtc_line_o = !mode_q && rtc_keep_q;

  // R10: entry silences both older sources and drops the PIT enable
  p_enter_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && !mode_q) |=> (!pit_en_o && !pit_line_o && !rtc_line_o));
  // R11: exit raises the enable and leaves the PIT wire low
  p_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && mode_q) |=> (pit_en_o && !pit_line_o));
  // R9: exit restores the recorded RTC level
  p_rtc_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && mode_q) |=> (rtc_line_o == $past(rtc_i)));
  // R10: PIT input cannot move its wire during takeover
  p_pit_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && mode_q) |=> !pit_line_o);
endmodule

// File: rtl/irq_line_router.sv
module irq_line_router #(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned NUM_LINES = 24,
  parameter int unsigned LEG0_LINE = 0,
  parameter int unsigned LEG1_LINE = 8,
  localparam int unsigned ROUTE_W  = $clog2(NUM_LINES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_CH-1:0]                ch_fire_i,
  input  logic [NUM_CH-1:0]                ch_clear_i,
  input  logic [NUM_CH-1:0]                ch_trig_i,
  input  logic [NUM_CH-1:0][ROUTE_W-1:0]   ch_route_i,
  input  logic                             legacy_mode_i,
  input  logic                             pit_irq_i,
  input  logic                             rtc_irq_i,
  output logic [NUM_LINES-1:0]             irq_o,
  output logic                             pit_enable_o
);
  logic                             takeover;
  logic                             pit_line;
  logic                             rtc_line;
  logic [NUM_CH-1:0]                ch_active;
  logic [NUM_CH-1:0][NUM_LINES-1:0] ch_hits;
  logic [NUM_LINES-1:0]             chan_or;

  irq_legacy_ctl u_legacy (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (legacy_mode_i),
    .pit_i      (pit_irq_i),
    .rtc_i      (rtc_irq_i),
    .takeover_o (takeover),
    .pit_en_o   (pit_enable_o),
    .pit_line_o (pit_line),
    .rtc_line_o (rtc_line)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    irq_chan_latch u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire_i   (ch_fire_i[c]),
      .clear_i  (ch_clear_i[c]),
      .trig_i   (ch_trig_i[c]),
      .active_o (ch_active[c])
    );
    irq_route_sel #(
      .NUM_LINES (NUM_LINES),
      .ROUTE_W   (ROUTE_W),
      .CH_IDX    (c),
      .LEG0_LINE (LEG0_LINE),
      .LEG1_LINE (LEG1_LINE)
    ) u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .route_i    (ch_route_i[c]),
      .takeover_i (takeover),
      .active_i   (ch_active[c]),
      .hit_o      (ch_hits[c])
    );
  end

  always_comb begin
    chan_or = '0;
    for (int c = 0; c < NUM_CH; c++) chan_or |= ch_hits[c];
  end

  always_comb begin
    irq_o            = chan_or;
    irq_o[LEG0_LINE] = chan_or[LEG0_LINE] | pit_line;
    irq_o[LEG1_LINE] = chan_or[LEG1_LINE] | rtc_line;
  end

  // R1: quiet wires and enabled PIT straight after reset
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (irq_o == '0 && pit_enable_o));
  // R7: a wire never rises with no channel active and no older source on it
  p_or_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_active == '0 && !pit_line && !rtc_line) |-> (irq_o == '0));
endmodule

// File: tb/irq_line_router_bench.sv
`timescale 1ns/1ps
module irq_line_router_bench;
  localparam int NCH = 4;
  localparam int NL  = 24;
  localparam int RW  = $clog2(NL);

  logic                     clk = 1'b0;
  logic                     rst_n;
  logic [NCH-1:0]           fire, clr, trig;
  logic [NCH-1:0][RW-1:0]   route;
  logic                     lmode, pit, rtc;
  logic [NL-1:0]            irq;
  logic                     pit_en;

  int vectors = 0;
  int miscompares = 0;
  string tag = "R1";

  // behavioural model state
  bit        m_hold [NCH];
  bit        m_pul  [NCH];
  int        m_rt   [NCH];
  bit        m_mode, m_pit_prev, m_pit_line, m_rtc;

  always #10 clk = ~clk;

  irq_line_router #(.NUM_CH(NCH), .NUM_LINES(NL)) u_irq_line_router (
    .clk(clk), .rst_n(rst_n), .ch_fire_i(fire), .ch_clear_i(clr),
    .ch_trig_i(trig), .ch_route_i(route), .legacy_mode_i(lmode),
    .pit_irq_i(pit), .rtc_irq_i(rtc), .irq_o(irq), .pit_enable_o(pit_en));

  task automatic model_tick();
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_hold[c] = 0; m_pul[c] = 0; m_rt[c] = 0;
      end
      m_mode = 0; m_pit_prev = 0; m_pit_line = 0; m_rtc = 0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (clr[c]) m_hold[c] = 0;
        else if (fire[c] && trig[c]) m_hold[c] = 1;
        m_pul[c] = fire[c] && !trig[c] && !clr[c];
        m_rt[c]  = int'(route[c]);
      end
      if (m_mode != lmode) m_pit_line = 0;
      else if (!lmode && pit != m_pit_prev) m_pit_line = pit;
      m_mode = lmode; m_pit_prev = pit; m_rtc = rtc;
    end
  endtask

  task automatic compare();
    logic [NL-1:0] e;
    int w;
    e = '0;
    for (int c = 0; c < NCH; c++) begin
      w = m_rt[c];
      if (m_mode && c == 0) w = 0;
      if (m_mode && c == 1) w = 8;
      if ((m_hold[c] || m_pul[c]) && w < NL) e[w] = 1'b1;
    end
    if (m_pit_line) e[0] = 1'b1;
    if (!m_mode && m_rtc) e[8] = 1'b1;
    vectors++;
    if (irq !== e || pit_en !== !m_mode) begin
      miscompares++;
      $display("FAIL %s irq=%h expected=%h pit_en=%b expected=%b",
               tag, irq, e, pit_en, !m_mode);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      model_tick();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic strobe(input int c);
    fire[c] = 1'b1; step(1); fire[c] = 1'b0;
  endtask

  task automatic wipe(input int c);
    clr[c] = 1'b1; step(1); clr[c] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fire = '0; clr = '0; trig = '0; route = '0;
    lmode = 1'b0; pit = 1'b0; rtc = 1'b0;
    @(negedge clk);
    // R1: reset state
    tag = "R1"; step(3);
    rst_n = 1'b1; step(2);

    // R2: level hold on a routed wire until clear
    tag = "R2"; route[2] = 5; trig[2] = 1'b1;
    strobe(2); step(4);
    wipe(2); step(2);

    // R3: edge pulses, single and back-to-back
    tag = "R3"; route[3] = 7; trig[3] = 1'b0;
    strobe(3); step(3);
    fire[3] = 1'b1; step(3); fire[3] = 1'b0; step(2);

    // R4: clear wins over same-cycle fire
    tag = "R4"; fire[2] = 1'b1; clr[2] = 1'b1; step(1);
    fire[2] = 1'b0; clr[2] = 1'b0; step(2);
    strobe(2); step(1);
    fire[2] = 1'b1; clr[2] = 1'b1; step(1);
    fire[2] = 1'b0; clr[2] = 1'b0; step(2);

    // R6: route use outside takeover, out-of-range route
    tag = "R6"; route[0] = 3; trig[0] = 1'b1; route[1] = 30; trig[1] = 1'b1;
    strobe(0); strobe(1); step(2);
    route[1] = 12; step(2);
    wipe(0); wipe(1); step(1);

    // R7: two channels on one wire
    tag = "R7"; route[2] = 10; route[3] = 10;
    strobe(2); strobe(3); step(1);
    fire[3] = 1'b1; clr[2] = 1'b1; step(1); clr[2] = 1'b0; step(1);
    fire[3] = 1'b0; step(2);

    // R8: pass-through of PIT and RTC
    tag = "R8"; pit = 1'b1; step(2); rtc = 1'b1; step(2);
    pit = 1'b0; rtc = 1'b0; step(2); pit = 1'b1; rtc = 1'b1; step(2);

    // R10: entering takeover with both older sources high
    tag = "R10"; lmode = 1'b1; step(2);
    pit = 1'b0; step(1); pit = 1'b1; step(1);
    // R5: pinned wires ignore route fields
    tag = "R5"; route[0] = 4; route[1] = 6; trig[1] = 1'b0;
    strobe(0); strobe(1); step(2);
    route[2] = 0; strobe(2); step(2);
    wipe(0); wipe(2); step(1);
    rtc = 1'b0; step(1); rtc = 1'b1; step(1);

    // R11 / R9: exit with PIT high and RTC high
    tag = "R11"; lmode = 1'b0; step(3);
    pit = 1'b0; step(2); pit = 1'b1; step(2);
    // R9: RTC dropped during takeover, visible right on exit
    tag = "R9"; lmode = 1'b1; step(2); rtc = 1'b0; step(2);
    lmode = 1'b0; step(2);
    rtc = 1'b1; lmode = 1'b1; step(1); lmode = 1'b0; step(1);
    lmode = 1'b1; step(1); lmode = 1'b0; pit = 1'b0; step(3);

    // R1: reset in mid-run
    tag = "R1"; route[2] = 9; trig[2] = 1'b1; strobe(2); lmode = 1'b1; step(1);
    rst_n = 1'b0; step(2); rst_n = 1'b1; lmode = 1'b0; step(2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule